// File: doc/BRIEF.md
# SPI Slave Controller with Byte FIFOs

This block is a serial-peripheral-interface slave that moves 8-bit characters between an external master and on-chip logic. It runs on the system clock, brings the master's serial clock, data-in line and active-low select into that domain through two-flop synchronizers, and turns their edges into sample and shift events. The system clock must run at least four times faster than the serial clock. Completed characters are queued in a small receive FIFO. Every character the master clocks in is matched by one character sent back, taken from a transmit FIFO. If that FIFO is empty, a fill byte is sent instead.

On-chip logic loads transmit bytes with a one-cycle push strobe and drains receive bytes with a one-cycle pop strobe. The receive head is always visible on `rx_data`. Three configuration inputs select the bit order, the idle level of the serial clock and the clock phase. Sticky error flags report a dropped receive byte, a transmit underrun and a push into a full transmit FIFO. A single interrupt output combines the enabled conditions.

Top module: `spi_slave_fifo`

## Requirements
- R1: `miso_oe` is 1 only while the synchronized select is active (low). When select is inactive, `miso_oe` is 0 and `miso` is 0.
- R2: Raising select clears the bit counter and the receive shift register. A character cut short by deselection is never queued, and the next select starts a fresh character.
- R3: Each FIFO holds exactly 4 bytes. `tx_full` is 1 when the transmit FIFO holds 4 bytes.
- R4: Received characters are queued in arrival order. `rx_valid` is 1 exactly while the receive FIFO holds at least one byte, and `rx_data` shows the oldest byte.
- R5: A character completed while the receive FIFO holds 4 bytes is discarded, and the sticky flag `rx_ovf` is set.
- R6: Each received character consumes exactly one transmit FIFO byte, which is sent during that same character. Bytes are sent in push order.
- R7: If the transmit FIFO is empty at the moment a character needs its byte, 0xFF is sent and the sticky flag `tx_und` is set.
- R8: `cfg_lsb_first` = 1 sends and receives bit 0 first; 0 sends and receives bit 7 first. The same order applies to both directions.
- R9: When `cfg_cpol` ^ `cfg_cpha` = 0, MOSI is sampled on the rising SCK edge; when it is 1, MOSI is sampled on the falling edge. With `cfg_cpha` = 0, the first bit is on MISO before the first SCK edge.
- R10: `flag_clr` bit 0 clears `rx_ovf`, bit 1 clears `tx_und` and bit 2 clears `tx_wr_err`. A new event in the same cycle keeps the flag set.
- R11: `irq` = (`irq_en[0]` & `rx_valid`) | (`irq_en[1]` & `rx_ovf`) | (`irq_en[2]` & `tx_und`).
- R12: A push into a full transmit FIFO is ignored and sets the sticky flag `tx_wr_err`. A pop from an empty receive FIFO changes nothing, and `rx_data` reads 0x00 while the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for miso |
| cfg_lsb_first | input | 1 | 1 = LSB first, 0 = MSB first |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_cpha | input | 1 | Clock phase select |
| tx_push | input | 1 | Push strobe for the transmit FIFO |
| tx_data | input | 8 | Byte to push |
| tx_full | output | 1 | Transmit FIFO holds 4 bytes |
| rx_pop | input | 1 | Pop strobe for the receive FIFO |
| rx_data | output | 8 | Oldest received byte, 0x00 when empty |
| rx_valid | output | 1 | Receive FIFO not empty |
| flag_clr | input | 3 | Clear strobes for sticky flags |
| irq_en | input | 3 | Interrupt enables |
| rx_ovf | output | 1 | Sticky receive overflow |
| tx_und | output | 1 | Sticky transmit underrun |
| tx_wr_err | output | 1 | Sticky push-while-full |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is the one where the receive FIFO is full and the transmit FIFO is empty while the master is still clocking. In that state, overflow and underrun must both occur in the same character, and neither FIFO may be corrupted. The bench gets there by preloading four transmit bytes and trying a fifth push. It then holds select for five back-to-back characters without popping anything. A deselect in the middle of a character is also driven, to show that a partial character is never queued but still consumes its transmit byte.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  localparam int CHAR_W = 8;
  localparam logic [CHAR_W-1:0] FILL_BYTE = 8'hFF;

  // receive shift: new bit enters at the end that leaves last
  function automatic logic [CHAR_W-1:0] rx_shift_in(input logic [CHAR_W-1:0] sh,
                                                   input logic bit_in,
                                                   input logic lsb_first);
    return lsb_first ? {bit_in, sh[CHAR_W-1:1]} : {sh[CHAR_W-2:0], bit_in};
  endfunction

  function automatic logic [CHAR_W-1:0] tx_advance(input logic [CHAR_W-1:0] sh,
                                                  input logic lsb_first);
    return lsb_first ? {1'b0, sh[CHAR_W-1:1]} : {sh[CHAR_W-2:0], 1'b0};
  endfunction

  function automatic logic tx_head_bit(input logic [CHAR_W-1:0] sh,
                                       input logic lsb_first);
    return lsb_first ? sh[0] : sh[CHAR_W-1];
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  // R3
  fifo_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R12
  full_push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_slave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selected,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              cfg_lsb_first,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              tx_empty,
  input  logic [CHAR_W-1:0] tx_head,
  output logic              tx_take,
  output logic              und_evt,
  output logic              char_done,
  output logic [CHAR_W-1:0] char_data,
  output logic              miso_bit
);
  localparam int CNT_W = $clog2(CHAR_W);

  logic              sck_prev;
  logic              rise, fall, sample_edge, shift_edge;
  logic [CNT_W-1:0]  cnt;
  logic              loaded, fresh, has_data;
  logic [CHAR_W-1:0] tx_sh, rx_sh, rx_next;
  logic              load_now, sample_now;

  assign rise        = sck_s && !sck_prev;
  assign fall        = !sck_s && sck_prev;
  assign sample_edge = (cfg_cpol ^ cfg_cpha) ? fall : rise;
  assign shift_edge  = (cfg_cpol ^ cfg_cpha) ? rise : fall;

  // byte is peeked at the slot start and committed on the first sample edge
  assign load_now   = selected && !loaded && (shift_edge || (fresh && !cfg_cpha));
  assign sample_now = selected && loaded && sample_edge;
  assign rx_next    = rx_shift_in(rx_sh, mosi_s, cfg_lsb_first);

  assign tx_take    = sample_now && (cnt == '0) && has_data;
  assign und_evt    = sample_now && (cnt == '0) && !has_data;
  assign char_done  = sample_now && (cnt == CNT_W'(CHAR_W - 1));
  assign char_data  = rx_next;
  assign miso_bit   = selected ? tx_head_bit(tx_sh, cfg_lsb_first) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      cnt      <= '0;
      loaded   <= 1'b0;
      fresh    <= 1'b1;
      has_data <= 1'b0;
      tx_sh    <= FILL_BYTE;
      rx_sh    <= '0;
    end else begin
      sck_prev <= sck_s;
      if (!selected) begin
        cnt    <= '0;
        loaded <= 1'b0;
        fresh  <= 1'b1;
        rx_sh  <= '0;
      end else begin
        if (load_now) begin
          tx_sh    <= tx_empty ? FILL_BYTE : tx_head;
          has_data <= !tx_empty;
          loaded   <= 1'b1;
          fresh    <= 1'b0;
        end else if (shift_edge && loaded && cnt != '0) begin
          tx_sh <= tx_advance(tx_sh, cfg_lsb_first);
        end
        if (sample_now) begin
          rx_sh <= rx_next;
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_W'(CHAR_W - 1)) loaded <= 1'b0;
        end
      end
    end
  end

  // R2
  fresh_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !$past(selected)) |-> (cnt == '0 && !loaded));

  // R6
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_take && und_evt));
endmodule

// File: rtl/spi_slave_fifo.sv
module spi_slave_fifo
  import spi_slave_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              ss_n,
  output logic              miso,
  output logic              miso_oe,
  input  logic              cfg_lsb_first,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              tx_push,
  input  logic [CHAR_W-1:0] tx_data,
  output logic              tx_full,
  input  logic              rx_pop,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic [2:0]        flag_clr,
  input  logic [2:0]        irq_en,
  output logic              rx_ovf,
  output logic              tx_und,
  output logic              tx_wr_err,
  output logic              irq
);
  logic              sck_s, mosi_s, ss_n_s, selected;
  logic              tx_empty, tx_take, und_evt, char_done;
  logic [CHAR_W-1:0] tx_head, char_data, rx_head;
  logic              rx_full, rx_empty;
  logic              ovf_evt, wr_err_evt;

  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ss_n, sck, mosi}), .q({ss_n_s, sck_s, mosi_s}));

  assign selected = !ss_n_s;

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CHAR_W)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
    .pop(tx_take), .head(tx_head), .full(tx_full), .empty(tx_empty));

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CHAR_W)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .push(char_done), .wdata(char_data),
    .pop(rx_pop), .head(rx_head), .full(rx_full), .empty(rx_empty));

  spi_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .selected(selected), .sck_s(sck_s),
    .mosi_s(mosi_s), .cfg_lsb_first(cfg_lsb_first), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .tx_empty(tx_empty), .tx_head(tx_head),
    .tx_take(tx_take), .und_evt(und_evt), .char_done(char_done),
    .char_data(char_data), .miso_bit(miso));

  assign miso_oe    = selected;
  assign rx_valid   = !rx_empty;
  assign rx_data    = rx_empty ? '0 : rx_head;
  assign ovf_evt    = char_done && rx_full;
  assign wr_err_evt = tx_push && tx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ovf    <= 1'b0;
      tx_und    <= 1'b0;
      tx_wr_err <= 1'b0;
    end else begin
      rx_ovf    <= ovf_evt    || (rx_ovf    && !flag_clr[0]);
      tx_und    <= und_evt    || (tx_und    && !flag_clr[1]);
      tx_wr_err <= wr_err_evt || (tx_wr_err && !flag_clr[2]);
    end
  end

  assign irq = (irq_en[0] && rx_valid) || (irq_en[1] && rx_ovf) || (irq_en[2] && tx_und);

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> rx_ovf);

  // R7
  und_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    und_evt |=> tx_und);

  // R10
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[0] && !ovf_evt) |=> !rx_ovf);

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso);
endmodule

// File: tb/spi_slave_fifo_bench.sv
module spi_slave_fifo_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic miso, miso_oe;
  logic cfg_lsb_first = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic tx_push = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_full;
  logic rx_pop = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid;
  logic [2:0] flag_clr = '0, irq_en = '0;
  logic rx_ovf, tx_und, tx_wr_err, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_slave_fifo u_spi_slave_fifo (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .ss_n(ss_n),
    .miso(miso), .miso_oe(miso_oe), .cfg_lsb_first(cfg_lsb_first),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .tx_push(tx_push),
    .tx_data(tx_data), .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
    .rx_valid(rx_valid), .flag_clr(flag_clr), .irq_en(irq_en),
    .rx_ovf(rx_ovf), .tx_und(tx_und), .tx_wr_err(tx_wr_err), .irq(irq));

  // {cpol, cpha, lsb_first, tx byte, mosi byte}
  localparam logic [18:0] VEC [8] = '{
    {3'b000, 8'hA5, 8'h3C}, {3'b010, 8'h81, 8'h7E},
    {3'b100, 8'hC3, 8'h12}, {3'b110, 8'h5A, 8'hF0},
    {3'b001, 8'h96, 8'h01}, {3'b011, 8'h0F, 8'h80},
    {3'b101, 8'h71, 8'hE4}, {3'b111, 8'hB2, 8'h4D}};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    tx_data = b; tx_push = 1'b1; clks(1); tx_push = 1'b0;
  endtask

  task automatic pop;
    rx_pop = 1'b1; clks(1); rx_pop = 1'b0;
  endtask

  task automatic sel;
    sck = cfg_cpol; clks(4); ss_n = 1'b0; clks(8);
  endtask

  task automatic desel;
    clks(6); ss_n = 1'b1; clks(10);
  endtask

  // one character with select already active; half period 6 system clocks
  task automatic xchg(input logic [7:0] mo, output logic [7:0] mi);
    mi = '0;
    for (int i = 0; i < 8; i++) begin
      int k;
      k = cfg_lsb_first ? i : 7 - i;
      if (!cfg_cpha) begin
        mosi = mo[k]; clks(6);
        sck = ~cfg_cpol; mi[k] = miso; clks(6);
        sck = cfg_cpol;
      end else begin
        sck = ~cfg_cpol; mosi = mo[k]; clks(6);
        sck = cfg_cpol; mi[k] = miso; clks(6);
      end
    end
  endtask

  initial begin
    clks(200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    clks(3); rst_n = 1'b1; clks(2);
    // reset state
    check("R1 reset miso_oe", miso_oe, 0);
    check("R4 reset rx_valid", rx_valid, 0);
    check("R12 reset rx_data", rx_data, 8'h00);
    check("R10 reset flags", {rx_ovf, tx_und, tx_wr_err, tx_full}, 0);
    check("R11 reset irq", irq, 0);

    // table walk: R6 R8 R9
    for (int v = 0; v < 8; v++) begin
      {cfg_cpol, cfg_cpha, cfg_lsb_first} = VEC[v][18:16];
      push(VEC[v][15:8]);
      sel();
      check("R1 miso_oe selected", miso_oe, 1);
      xchg(VEC[v][7:0], got);
      check($sformatf("R6 R8 R9 miso vec%0d", v), got, VEC[v][15:8]);
      desel();
      check("R1 miso_oe idle", {miso_oe, miso}, 0);
      check($sformatf("R4 R8 R9 rx vec%0d", v), {rx_valid, rx_data}, {1'b1, VEC[v][7:0]});
      pop();
      check("R4 drained", rx_valid, 0);
    end
    check("R7 no underrun in table", tx_und, 0);

    // R2: partial char consumes one tx byte, is not queued
    {cfg_cpol, cfg_cpha, cfg_lsb_first} = 3'b000;
    push(8'h11); push(8'h22);
    sel();
    for (int i = 0; i < 4; i++) begin
      mosi = 1'b1; clks(6); sck = 1'b1; clks(6); sck = 1'b0;
    end
    desel();
    check("R2 partial not queued", rx_valid, 0);
    sel(); xchg(8'h6B, got); desel();
    check("R2 fresh frame miso", got, 8'h22);
    check("R2 fresh frame rx", rx_data, 8'h6B);
    pop();

    // R3 R12: fill tx, overfill
    push(8'hD1); push(8'hD2); push(8'hD3);
    check("R3 not full at 3", tx_full, 0);
    push(8'hD4);
    check("R3 full at 4", tx_full, 1);
    push(8'hEE);
    check("R12 wr err set", tx_wr_err, 1);

    // R5 R7: five characters, no pops
    sel();
    for (int c = 0; c < 5; c++) begin
      xchg(8'h40 + 8'(c), got);
      check($sformatf("R6 R7 miso char%0d", c), got, (c < 4) ? 8'hD1 + 8'(c) : 8'hFF);
    end
    desel();
    check("R7 underrun flag", tx_und, 1);
    check("R5 overflow flag", rx_ovf, 1);

    // R11
    irq_en = 3'b000; clks(1); check("R11 none enabled", irq, 0);
    irq_en = 3'b010; clks(1); check("R11 ovf enabled", irq, 1);
    irq_en = 3'b100; clks(1); check("R11 und enabled", irq, 1);

    // R10 clear
    flag_clr = 3'b111; clks(1); flag_clr = 3'b000;
    check("R10 flags cleared", {rx_ovf, tx_und, tx_wr_err}, 0);
    irq_en = 3'b110; clks(1); check("R11 cleared irq", irq, 0);
    irq_en = 3'b001; clks(1); check("R11 rx_valid irq", irq, 1);

    // R4 R5: four kept, fifth dropped
    for (int c = 0; c < 4; c++) begin
      check($sformatf("R4 R5 rx order %0d", c), rx_data, 8'h40 + 8'(c));
      pop();
    end
    check("R5 fifth dropped", rx_valid, 0);
    pop();
    check("R12 empty pop reads zero", {rx_valid, rx_data}, 0);
    check("R11 empty irq", irq, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule